// File: doc/BRIEF.md
# Relocatable Byte-Addressable On-Chip RAM

This block is a 4 KB general-purpose memory, 1024 words of 32 bits, inside a larger controller. An external bus target port reaches it through a 4 KB window whose base is held in a writable base register, so the window can sit anywhere in a 32-bit address space. External reads and writes complete after a fixed number of target wait states. Writes are byte-granular and a read always returns the whole word.

A second port serves word fetches for an embedded script engine. Those fetches are answered directly from the array and never show up on the external bus handshake. Both ports share one array port. A fetch therefore wins any cycle it shares with an external access, and that access slips by one cycle.

A static strap input switches the whole memory on or off. A mirror control input makes the scratch register read back the RAM base address, which lets script loaders pick up the window location.

Top module: `reloc_ram`

## Requirements
- R1: The array holds 1024 words of 32 bits. The word index is external address bits [11:2], and every index from 0 to 1023 can be written and read back.
- R2: An external write updates only the byte lanes whose enable bit is 1. Bit k of the enable covers data bits [8k+7:8k]. An external read returns all 32 bits whatever the enables are.
- R3: The base register keeps bits [31:12] of a write. Its bits [11:0] always read 0. It resets to 0.
- R4: The block claims an external access only when address bits [31:12] equal base bits [31:12]. For any other address, the ready output stays low.
- R5: With no fetch in the way, a claimed external access raises ready for one cycle, after the third rising edge that samples the request. That gives three wait cycles with ready low.
- R6: The external read data is valid in the cycle in which ready is high.
- R7: A fetch request raises the fetch valid output one cycle later, with the word at the fetch index. A fetch never raises the external ready.
- R8: When a fetch and a claimed external access share a cycle, the fetch is served in that cycle and the external ready comes one cycle later than in R5.
- R9: With mirror off, the scratch register reads back its last written value. With mirror on, it reads the base register. Mirror does not change the stored scratch value.
- R10: While the strap is low, external accesses get no ready, writes leave the array unchanged, and fetches give no valid.
- R11: After reset, ready and fetch valid are low and the base and scratch registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ram_on | input | 1 | Static enable strap, high turns the memory on |
| ext_addr | input | 32 | External byte address |
| ext_be | input | 4 | External byte lane enables |
| ext_rd | input | 1 | External read strobe, held until ready |
| ext_wr | input | 1 | External write strobe, held until ready |
| ext_wdata | input | 32 | External write data |
| ext_rdata | output | 32 | External read data, valid with ready |
| ext_ready | output | 1 | One-cycle access completion |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | 32 | Base register write data |
| base_q | output | 32 | Base register value, bits [11:0] zero |
| scr_wr | input | 1 | Scratch register write strobe |
| scr_wdata | input | 32 | Scratch register write data |
| mirror_on | input | 1 | Scratch readback shows the base when high |
| scr_q | output | 32 | Scratch register readback |
| fetch_req | input | 1 | Engine fetch request |
| fetch_word | input | 10 | Engine fetch word index |
| fetch_data | output | 32 | Fetched word, valid with fetch_valid |
| fetch_valid | output | 1 | Fetch data valid |

## Verification
An engine fetch and an external access can land in the same cycle and compete for the single array port. The bench raises a one-cycle fetch on the same clock edge on which it starts an external read. The fetched word must then arrive on the next edge, and the external ready must arrive on the fourth sampling edge instead of the third. Both results are popped from the scoreboard queues and compared, so the read data must also come from the external index and not from the fetch index.

// File: rtl/reloc_ram_pkg.sv
// Shared sizing constants for the relocatable RAM.
// Assumes a byte-addressed bus and word-aligned array entries.
package reloc_ram_pkg;
    localparam int unsigned RAM_WORDS  = 1024;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned WAIT_STATES = 3;
endpackage

// File: rtl/reloc_ram_window.sv
// Address window decoder: claims addresses whose upper bits match the base.
// Assumes the window size is a power of two aligned to its own size.
module reloc_ram_window #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-OFF_W-1:0] base_hi,
    output logic              hit
);
    // Compare the upper address bits against the programmed base.
    always_comb begin
        hit = en && (addr[ADDR_W-1:OFF_W] == base_hi);
    end
endmodule

// File: rtl/reloc_ram_core.sv
// Single-port word array with per-byte write enables and a registered read.
// Assumes at most one operation per cycle; the caller arbitrates.
module reloc_ram_core #(
    parameter int unsigned WORDS  = 1024,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(WORDS),
    localparam int unsigned NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic              op_we,
    input  logic [NB-1:0]     op_be,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [DATA_W-1:0] op_wdata,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] mem [WORDS];

    // Write the enabled byte lanes of the addressed word.
    always_ff @(posedge clk) begin
        if (op_en && op_we) begin
            for (int b = 0; b < int'(NB); b++) begin
                if (op_be[b]) begin
                    mem[op_idx][b*8 +: 8] <= op_wdata[b*8 +: 8];
                end
            end
        end
    end

    // Register the addressed word on a read operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (op_en && !op_we) begin
            rd_q <= mem[op_idx];
        end
    end
endmodule

// File: rtl/reloc_ram_seq.sv
// External access sequencer: counts target wait states and issues the
// array operation and a one-cycle ready. Assumes the master holds its
// strobe until ready. A hold input freezes the count for one cycle.
module reloc_ram_seq #(
    parameter int unsigned WAITS = 3,
    localparam int unsigned CW   = $clog2(WAITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic hit,
    input  logic hold,
    output logic go,
    output logic ready
);
    logic [CW-1:0] cnt;
    logic          live;

    // A claimed access that the array can take this cycle.
    always_comb begin
        live = acc && hit && !ready;
        go   = live && !hold && (cnt == CW'(WAITS - 1));
    end

    // Advance the wait count and raise ready after the last wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (ready) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (live) begin
            if (!hold) begin
                if (go) begin
                    cnt   <= '0;
                    ready <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else begin
            cnt <= '0;
        end
    end

    p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    p_wait_cycles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(acc, 1) && $past(acc, 2) && $past(acc, 3)));
    p_hold_delays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !$rose(ready));
endmodule

// File: rtl/reloc_ram.sv
// Relocatable 4 KB RAM: external target port with a programmable window,
// an engine fetch port with priority, a strap enable and a scratch
// register that can mirror the base. Assumes synchronous active-low reset.
module reloc_ram
    import reloc_ram_pkg::*;
#(
    parameter int unsigned WORDS  = RAM_WORDS,
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned WAITS  = WAIT_STATES,
    localparam int unsigned IDX_W = $clog2(WORDS),
    localparam int unsigned OFF_W = IDX_W + 2,
    localparam int unsigned NB    = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ram_on,
    input  logic [AW-1:0]    ext_addr,
    input  logic [NB-1:0]    ext_be,
    input  logic             ext_rd,
    input  logic             ext_wr,
    input  logic [DW-1:0]    ext_wdata,
    output logic [DW-1:0]    ext_rdata,
    output logic             ext_ready,
    input  logic             base_wr,
    input  logic [AW-1:0]    base_wdata,
    output logic [AW-1:0]    base_q,
    input  logic             scr_wr,
    input  logic [DW-1:0]    scr_wdata,
    input  logic             mirror_on,
    output logic [DW-1:0]    scr_q,
    input  logic             fetch_req,
    input  logic [IDX_W-1:0] fetch_word,
    output logic [DW-1:0]    fetch_data,
    output logic             fetch_valid
);
    logic [AW-OFF_W-1:0] base_hi;
    logic [DW-1:0]       scratch;
    logic                win_hit;
    logic                fetch_go;
    logic                ext_go;
    logic                op_en;
    logic                op_we;
    logic [IDX_W-1:0]    op_idx;
    logic [DW-1:0]       rd_q;
    logic                unused_bits;

    assign unused_bits = ^{ext_addr[1:0], base_wdata[OFF_W-1:0]};

    // Hold the base upper bits and the scratch value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            scratch <= '0;
        end else begin
            if (base_wr) base_hi <= base_wdata[AW-1:OFF_W];
            if (scr_wr)  scratch <= scr_wdata;
        end
    end

    // Present the base aligned to the window and the scratch readback.
    always_comb begin
        base_q = {base_hi, {OFF_W{1'b0}}};
        scr_q  = mirror_on ? DW'(base_q) : scratch;
    end

    reloc_ram_window #(.ADDR_W(AW), .OFF_W(OFF_W)) i_window (
        .en      (ram_on),
        .addr    (ext_addr),
        .base_hi (base_hi),
        .hit     (win_hit)
    );

    // An enabled fetch owns the array port in its cycle.
    assign fetch_go = ram_on && fetch_req;

    reloc_ram_seq #(.WAITS(WAITS)) i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (ext_rd || ext_wr),
        .hit   (win_hit),
        .hold  (fetch_go),
        .go    (ext_go),
        .ready (ext_ready)
    );

    // Steer the single array port to the fetch or the external access.
    always_comb begin
        op_en  = fetch_go || ext_go;
        op_we  = !fetch_go && ext_wr;
        op_idx = fetch_go ? fetch_word : ext_addr[OFF_W-1:2];
    end

    reloc_ram_core #(.WORDS(WORDS), .DATA_W(DW)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_en    (op_en),
        .op_we    (op_we),
        .op_be    (ext_be),
        .op_idx   (op_idx),
        .op_wdata (ext_wdata),
        .rd_q     (rd_q)
    );

    // Flag fetched data one cycle after an enabled fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_valid <= 1'b0;
        else        fetch_valid <= fetch_go;
    end

    assign fetch_data = rd_q;
    assign ext_rdata  = rd_q;

    p_strap_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_on |=> (!ext_ready && !fetch_valid));
    p_fetch_served_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> fetch_valid);
    p_claimed_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_ready) |-> $past(win_hit));
endmodule

// File: tb/test_reloc_ram.sv
module test_reloc_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_on = 1'b1;
    logic [31:0] ext_addr = '0;
    logic [3:0]  ext_be = '0;
    logic        ext_rd = 1'b0;
    logic        ext_wr = 1'b0;
    logic [31:0] ext_wdata = '0;
    logic [31:0] ext_rdata;
    logic        ext_ready;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic [31:0] base_q;
    logic        scr_wr = 1'b0;
    logic [31:0] scr_wdata = '0;
    logic        mirror_on = 1'b0;
    logic [31:0] scr_q;
    logic        fetch_req = 1'b0;
    logic [9:0]  fetch_word = '0;
    logic [31:0] fetch_data;
    logic        fetch_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { bit rd; logic [31:0] d; string tag; } bus_item_t;
    bus_item_t   bq[$];
    logic [31:0] fq[$];
    string       ftag[$];

    always #2.5 clk = ~clk;

    reloc_ram i_reloc_ram (
        .clk(clk), .rst_n(rst_n), .ram_on(ram_on),
        .ext_addr(ext_addr), .ext_be(ext_be), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ready(ext_ready),
        .base_wr(base_wr), .base_wdata(base_wdata), .base_q(base_q),
        .scr_wr(scr_wr), .scr_wdata(scr_wdata), .mirror_on(mirror_on), .scr_q(scr_q),
        .fetch_req(fetch_req), .fetch_word(fetch_word),
        .fetch_data(fetch_data), .fetch_valid(fetch_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected results as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fetch_valid) begin
                if (fq.size() == 0) chk(1'b0, "R7/R10 unexpected fetch valid", 32'h1, 32'h0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = fq.pop_front();
                    t = ftag.pop_front();
                    chk(fetch_data == e, t, fetch_data, e);
                end
            end
            if (ext_ready) begin
                if (bq.size() == 0) chk(1'b0, "R4/R7/R10 unexpected ready", 32'h1, 32'h0);
                else begin
                    bus_item_t it;
                    it = bq.pop_front();
                    if (it.rd) chk(ext_rdata == it.d, it.tag, ext_rdata, it.d);
                end
            end
        end
    end

    // Driver: one external access; exp_n is the sample that sees ready (0 = never).
    task automatic bus(input bit wr, input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input logic [31:0] exp_rd,
                       input int exp_n, input bit with_fetch, input logic [9:0] fw,
                       input logic [31:0] fexp, input string tag);
        int n = 0;
        @(negedge clk);
        if (exp_n != 0) bq.push_back('{rd: !wr, d: exp_rd, tag: tag});
        if (with_fetch) begin
            fq.push_back(fexp);
            ftag.push_back({tag, " fetch"});
            fetch_req  = 1'b1;
            fetch_word = fw;
        end
        ext_addr = a; ext_be = be; ext_wdata = wd;
        ext_wr = wr; ext_rd = !wr;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == 1) fetch_req = 1'b0;
            if (ext_ready) begin n = i; break; end
        end
        ext_rd = 1'b0; ext_wr = 1'b0;
        chk(n == exp_n, {tag, " ready timing"}, n, exp_n);
    endtask

    task automatic fetch(input logic [9:0] w, input logic [31:0] e, input string tag);
        @(negedge clk);
        fq.push_back(e);
        ftag.push_back(tag);
        fetch_req = 1'b1; fetch_word = w;
        @(negedge clk);
        fetch_req = 1'b0;
        chk(ext_ready == 1'b0, {tag, " no bus ready"}, ext_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_ready == 0, "R11 ready", ext_ready, 0);
        chk(fetch_valid == 0, "R11 fetch valid", fetch_valid, 0);
        chk(base_q == 0, "R11 base", base_q, 0);
        chk(scr_q == 0, "R11 scratch", scr_q, 0);

        base_wdata = 32'h1234_5FFF; base_wr = 1'b1;
        @(negedge clk); base_wr = 1'b0;
        chk(base_q == 32'h1234_5000, "R3 base low bits", base_q, 32'h1234_5000);

        bus(1, 32'h1234_5000, 4'hF, 32'hA5A5_0001, 0, 3, 0, 0, 0, "R5 write word0");
        bus(1, 32'h1234_5FFC, 4'hF, 32'hDEAD_BEEF, 0, 3, 0, 0, 0, "R1 write word1023");
        bus(1, 32'h1234_5014, 4'hF, 32'h1122_3344, 0, 3, 0, 0, 0, "R1 write word5");
        bus(0, 32'h1234_5000, 4'hF, 0, 32'hA5A5_0001, 3, 0, 0, 0, "R6 read word0");
        bus(0, 32'h1234_5FFC, 4'hF, 0, 32'hDEAD_BEEF, 3, 0, 0, 0, "R1 read word1023");
        bus(1, 32'h1234_5014, 4'b0101, 32'hFFFF_FFFF, 0, 3, 0, 0, 0, "R2 byte write");
        bus(0, 32'h1234_5014, 4'b0000, 0, 32'h11FF_33FF, 3, 0, 0, 0, "R2 full read");
        bus(0, 32'h1234_4FFC, 4'hF, 0, 0, 0, 0, 0, 0, "R4 below window");
        bus(0, 32'h1234_6000, 4'hF, 0, 0, 0, 0, 0, 0, "R4 above window");

        base_wdata = 32'h8000_0ABC; base_wr = 1'b1;
        @(negedge clk); base_wr = 1'b0;
        chk(base_q == 32'h8000_0000, "R3 relocate", base_q, 32'h8000_0000);
        bus(0, 32'h8000_0000, 4'hF, 0, 32'hA5A5_0001, 3, 0, 0, 0, "R4 new window");
        bus(0, 32'h1234_5000, 4'hF, 0, 0, 0, 0, 0, 0, "R4 old window");

        fetch(10'd0, 32'hA5A5_0001, "R7 fetch word0");
        fetch(10'd1023, 32'hDEAD_BEEF, "R7 fetch word1023");
        bus(0, 32'h8000_0014, 4'hF, 0, 32'h11FF_33FF, 4, 1, 10'd1023, 32'hDEAD_BEEF, "R8 collision");

        scr_wdata = 32'hCAFE_F00D; scr_wr = 1'b1;
        @(negedge clk); scr_wr = 1'b0;
        chk(scr_q == 32'hCAFE_F00D, "R9 scratch plain", scr_q, 32'hCAFE_F00D);
        mirror_on = 1'b1;
        @(negedge clk);
        chk(scr_q == 32'h8000_0000, "R9 mirror base", scr_q, 32'h8000_0000);
        mirror_on = 1'b0;
        @(negedge clk);
        chk(scr_q == 32'hCAFE_F00D, "R9 scratch kept", scr_q, 32'hCAFE_F00D);

        ram_on = 1'b0;
        bus(1, 32'h8000_0000, 4'hF, 32'h0, 0, 0, 0, 0, 0, "R10 write off");
        @(negedge clk);
        fetch_req = 1'b1; fetch_word = 10'd0;
        @(negedge clk);
        fetch_req = 1'b0;
        chk(fetch_valid == 0, "R10 fetch off", fetch_valid, 0);
        ram_on = 1'b1;
        bus(0, 32'h8000_0000, 4'hF, 0, 32'hA5A5_0001, 3, 0, 0, 0, "R10 contents kept");

        repeat (3) @(negedge clk);
        chk(bq.size() == 0 && fq.size() == 0, "R6/R7 queues drained", bq.size() + fq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule